// File: doc/BRIEF.md
# Bufferless Deflection Mesh Router

This block is the switching element at one node of a two-dimensional mesh. It holds no input queues. In each cycle, up to four flits can arrive on the neighbour links, and the local port can offer one new flit for injection. Every flit that arrives leaves in the same routing step. A flit addressed to this node is ejected to the local output. Each other flit goes to a direction that brings it closer to its destination if such a direction is still free. When no such direction is free, the flit is pushed out through another free link. This is a deflection: the flit is neither queued nor dropped.

Older flits choose first. The output of the routing step is captured in one pipeline latch, so each flit leaves the router one clock after it arrived. Links that would lead off the edge of the mesh are fixed by the node's coordinate parameters. The router never uses them and ignores anything presented on them. A new local flit is accepted only when a link is still free after all arriving flits have been placed.

Top module: `deflect_router`

## Requirements
- R1: Outputs are registered. A flit presented before a rising edge appears on its output right after that edge. During reset, and after it, every output valid is low until a flit has passed through.
- R2: Flit layout from bit 0 upward is destination x (X_W bits), destination y (Y_W bits), age (AGE_W bits), then payload (PLD_W bits). A flit whose destination equals (MY_X, MY_Y) is ejected on the local output. At most one flit is ejected per cycle, and the first one in priority order wins.
- R3: Arriving flits are served in priority order. A larger age goes first. On equal age, the lower link index goes first, with North=0, South=1, East=2 and West=3.
- R4: A productive link is East when destination x is above MY_X, West when it is below, North when destination y is above MY_Y, and South when it is below. The x-direction link is tried first and the y-direction link second.
- R5: Some flits have no free productive link, and some are addressed here but lose the ejection. Each such flit is deflected to the lowest-index free existing link.
- R6: Flits leaving in a cycle equal flits that arrived on existing links in the previous cycle plus the flit injected then. No flit is lost or duplicated.
- R7: Every departing flit, including ejected and injected ones, has its age increased by one. At the largest value the age stays unchanged.
- R8: inj_ok is high in a cycle exactly when inj_vld is high and a link is still free after all arrivals are placed. The injected flit is placed after all arrivals by the rules of R4 and R5, and it is never ejected.
- R9: Links that point off the mesh (North if MY_Y=MESH_Y-1, South if MY_Y=0, East if MY_X=MESH_X-1, West if MY_X=0) never carry an output. Flits presented on them are ignored.
- R10: Destination and payload fields leave unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 4 | Arrival valid per link (N,S,E,W = bits 0..3) |
| in_flit | input | 4*FW | Arriving flits, link i at bits i*FW |
| inj_vld | input | 1 | Local node offers a flit |
| inj_flit | input | FW | Flit offered for injection |
| inj_ok | output | 1 | Offered flit accepted this cycle |
| out_vld | output | 4 | Departing flit valid per link |
| out_flit | output | 4*FW | Departing flits, link i at bits i*FW |
| ej_vld | output | 1 | Flit ejected to the local node |
| ej_flit | output | FW | Ejected flit |

## Verification
The main function is first tried with all four links carrying flits to the same productive direction at mixed and tied ages. This separates the age ordering from the index tie-break and shows the deflection targets. Two flits addressed to the node at once show that only one ejects and that the older one wins. An age already at its maximum shows saturation. Full arrivals against a pending injection separate refusal from acceptance. A corner node that receives the same traffic shows that its missing links stay silent and that its two remaining links block injection sooner. Long random traffic then mixes all of these cases against a behavioural model on every clock.

// File: rtl/defr_pkg.sv
package defr_pkg;
  localparam int NLINK = 4;
  localparam int PN = 0;
  localparam int PS = 1;
  localparam int PE = 2;
  localparam int PW = 3;

  // x-direction productive link first, then y, else lowest free link
  function automatic logic [1:0] pick_port(input logic [3:0] free, input logic [3:0] prod);
    logic [3:0] hit;
    logic [1:0] r;
    hit = free & prod;
    r   = 2'd0;
    if (hit[PE])      r = 2'd2;
    else if (hit[PW]) r = 2'd3;
    else if (hit[PN]) r = 2'd0;
    else if (hit[PS]) r = 2'd1;
    else begin
      for (int i = NLINK - 1; i >= 0; i--) begin
        if (free[i]) r = 2'(i);
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/defr_route.sv
module defr_route #(
  parameter int X_W  = 2,
  parameter int Y_W  = 2,
  parameter int MY_X = 1,
  parameter int MY_Y = 1
) (
  input  logic [X_W-1:0] dst_x,
  input  logic [Y_W-1:0] dst_y,
  output logic [3:0]     prod
);
  import defr_pkg::*;
  localparam logic [X_W-1:0] HX = X_W'(MY_X);
  localparam logic [Y_W-1:0] HY = Y_W'(MY_Y);

  // R4: productive directions; none set means the flit is addressed here
  always_comb begin
    prod     = '0;
    prod[PE] = dst_x > HX;
    prod[PW] = dst_x < HX;
    prod[PN] = dst_y > HY;
    prod[PS] = dst_y < HY;
  end
endmodule

// File: rtl/defr_rank.sv
module defr_rank #(
  parameter int SLOTS = 4,
  parameter int AGE_W = 3,
  localparam int RW = $clog2(SLOTS)
) (
  input  logic [SLOTS-1:0] vld,
  input  logic [AGE_W-1:0] age  [SLOTS],
  output logic [RW-1:0]    rank [SLOTS]
);
  // R3: rank = number of valid slots that beat this one
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    always_comb begin
      logic [RW-1:0] cnt;
      cnt = '0;
      for (int j = 0; j < SLOTS; j++) begin
        if (j != i && vld[j] &&
            ((age[j] > age[i]) || ((age[j] == age[i]) && (j < i))))
          cnt = cnt + 1'b1;
      end
      rank[i] = cnt;
    end
  end
endmodule

// File: rtl/defr_alloc.sv
module defr_alloc #(
  parameter int SLOTS = 4,
  localparam int RW = $clog2(SLOTS)
) (
  input  logic [3:0]       links,
  input  logic [SLOTS-1:0] vld,
  input  logic [3:0]       prod     [SLOTS],
  input  logic [RW-1:0]    rank     [SLOTS],
  input  logic             inj_vld,
  input  logic [3:0]       inj_prod,
  output logic [SLOTS-1:0] to_link,
  output logic [1:0]       link_of  [SLOTS],
  output logic             ej_hit,
  output logic [RW-1:0]    ej_sel,
  output logic             inj_ok,
  output logic [1:0]       inj_link
);
  import defr_pkg::*;

  always_comb begin
    logic [3:0] free;
    logic [1:0] p;
    free    = links;
    p       = '0;
    ej_hit  = 1'b0;
    ej_sel  = '0;
    to_link = '0;
    for (int i = 0; i < SLOTS; i++) link_of[i] = '0;
    // serve slots in rank order (R3)
    for (int k = 0; k < SLOTS; k++) begin
      for (int i = 0; i < SLOTS; i++) begin
        if (vld[i] && rank[i] == RW'(k)) begin
          if (prod[i] == 4'b0000 && !ej_hit) begin   // R2
            ej_hit = 1'b1;
            ej_sel = RW'(i);
          end else begin                               // R4, R5
            p          = pick_port(free, prod[i]);
            link_of[i] = p;
            to_link[i] = 1'b1;
            free[p]    = 1'b0;
          end
        end
      end
    end
    // R8: injection takes a leftover link
    inj_ok   = inj_vld && (free != 4'b0000);
    inj_link = pick_port(free, inj_prod);
  end
endmodule

// File: rtl/deflect_router.sv
module deflect_router #(
  parameter int MESH_X = 4,
  parameter int MESH_Y = 4,
  parameter int MY_X   = 1,
  parameter int MY_Y   = 1,
  parameter int X_W    = 2,
  parameter int Y_W    = 2,
  parameter int AGE_W  = 3,
  parameter int PLD_W  = 8,
  localparam int FW    = X_W + Y_W + AGE_W + PLD_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      in_vld,
  input  logic [4*FW-1:0] in_flit,
  input  logic            inj_vld,
  input  logic [FW-1:0]   inj_flit,
  output logic            inj_ok,
  output logic [3:0]      out_vld,
  output logic [4*FW-1:0] out_flit,
  output logic            ej_vld,
  output logic [FW-1:0]   ej_flit
);
  import defr_pkg::*;
  localparam int AGE_LO = X_W + Y_W;
  localparam int SLOTS  = NLINK;
  localparam int RW     = $clog2(SLOTS);
  // R9: links that exist at this node (W,E,S,N)
  localparam logic [3:0] LINKS = {(MY_X > 0), (MY_X < MESH_X - 1),
                                  (MY_Y > 0), (MY_Y < MESH_Y - 1)};

  logic [FW-1:0]    arr [SLOTS];
  logic [SLOTS-1:0] arr_vld;
  logic [AGE_W-1:0] arr_age [SLOTS];
  logic [3:0]       prod [SLOTS];
  logic [3:0]       inj_prod;
  logic [RW-1:0]    rank [SLOTS];
  logic [SLOTS-1:0] to_link;
  logic [1:0]       link_of [SLOTS];
  logic             ej_hit;
  logic [RW-1:0]    ej_sel;
  logic [1:0]       inj_link;

  assign arr_vld = in_vld & LINKS;   // R9

  for (genvar i = 0; i < SLOTS; i++) begin : g_in
    assign arr[i]     = in_flit[i*FW +: FW];
    assign arr_age[i] = arr[i][AGE_LO +: AGE_W];
    defr_route #(.X_W(X_W), .Y_W(Y_W), .MY_X(MY_X), .MY_Y(MY_Y)) u_route (
      .dst_x (arr[i][0 +: X_W]),
      .dst_y (arr[i][X_W +: Y_W]),
      .prod  (prod[i])
    );
  end

  defr_route #(.X_W(X_W), .Y_W(Y_W), .MY_X(MY_X), .MY_Y(MY_Y)) u_inj_route (
    .dst_x (inj_flit[0 +: X_W]),
    .dst_y (inj_flit[X_W +: Y_W]),
    .prod  (inj_prod)
  );

  defr_rank #(.SLOTS(SLOTS), .AGE_W(AGE_W)) u_rank (
    .vld  (arr_vld),
    .age  (arr_age),
    .rank (rank)
  );

  defr_alloc #(.SLOTS(SLOTS)) u_alloc (
    .links    (LINKS),
    .vld      (arr_vld),
    .prod     (prod),
    .rank     (rank),
    .inj_vld  (inj_vld),
    .inj_prod (inj_prod),
    .to_link  (to_link),
    .link_of  (link_of),
    .ej_hit   (ej_hit),
    .ej_sel   (ej_sel),
    .inj_ok   (inj_ok),
    .inj_link (inj_link)
  );

  // R7: saturating age increment
  function automatic logic [FW-1:0] age_up(input logic [FW-1:0] f);
    logic [FW-1:0]    r;
    logic [AGE_W-1:0] a;
    r = f;
    a = f[AGE_LO +: AGE_W];
    if (a != {AGE_W{1'b1}}) a = a + 1'b1;
    r[AGE_LO +: AGE_W] = a;
    return r;
  endfunction

  // next-state crossbar
  logic [3:0]    nx_vld;
  logic [FW-1:0] nx_flit [NLINK];
  logic          nx_ej_vld;
  logic [FW-1:0] nx_ej_flit;

  always_comb begin
    nx_vld = '0;
    for (int p = 0; p < NLINK; p++) nx_flit[p] = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (to_link[i]) begin
        nx_vld[link_of[i]]  = 1'b1;
        nx_flit[link_of[i]] = age_up(arr[i]);
      end
    end
    if (inj_ok) begin
      nx_vld[inj_link]  = 1'b1;
      nx_flit[inj_link] = age_up(inj_flit);
    end
    nx_ej_vld  = ej_hit;
    nx_ej_flit = age_up(arr[ej_sel]);
  end

  // pipeline latch (R1): valids reset, data loaded on enable
  logic [3:0]    q_vld;
  logic [FW-1:0] q_flit [NLINK];
  logic          q_ej_vld;
  logic [FW-1:0] q_ej_flit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_vld    <= '0;
      q_ej_vld <= 1'b0;
    end else begin
      q_vld    <= nx_vld;
      q_ej_vld <= nx_ej_vld;
    end
  end

  for (genvar p = 0; p < NLINK; p++) begin : g_out
    always_ff @(posedge clk) begin
      if (nx_vld[p]) q_flit[p] <= nx_flit[p];
    end
    assign out_flit[p*FW +: FW] = q_flit[p];
  end

  always_ff @(posedge clk) begin
    if (nx_ej_vld) q_ej_flit <= nx_ej_flit;
  end

  assign out_vld = q_vld;
  assign ej_vld  = q_ej_vld;
  assign ej_flit = q_ej_flit;
endmodule

// File: rtl/defr_checker.sv
module defr_checker #(
  parameter int MESH_X = 4,
  parameter int MESH_Y = 4,
  parameter int MY_X   = 1,
  parameter int MY_Y   = 1,
  parameter int X_W    = 2,
  parameter int Y_W    = 2,
  parameter int AGE_W  = 3,
  parameter int PLD_W  = 8,
  localparam int FW    = X_W + Y_W + AGE_W + PLD_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    in_vld,
  input logic          inj_vld,
  input logic          inj_ok,
  input logic [3:0]    out_vld,
  input logic          ej_vld,
  input logic [FW-1:0] ej_flit
);
  localparam logic [3:0] EDGE_OK = {(MY_X > 0), (MY_X < MESH_X - 1),
                                    (MY_Y > 0), (MY_Y < MESH_Y - 1)};

  logic [3:0] due;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) due <= '0;
    else        due <= 4'($countones(in_vld & EDGE_OK)) + 4'(inj_ok);
  end

  AST_FLIT_CONSERVE: assert property (@(posedge clk) disable iff (!rst_n)
    (4'($countones(out_vld)) + 4'(ej_vld)) == due);                       // R6

  AST_EDGE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld & ~EDGE_OK) == 4'b0000);                                     // R9

  AST_EJECT_HERE: assert property (@(posedge clk) disable iff (!rst_n)
    ej_vld |-> (ej_flit[0 +: X_W] == X_W'(MY_X)) && (ej_flit[X_W +: Y_W] == Y_W'(MY_Y))); // R2

  AST_EJECT_AGED: assert property (@(posedge clk) disable iff (!rst_n)
    ej_vld |-> ej_flit[X_W+Y_W +: AGE_W] != '0);                          // R7

  AST_EJECT_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    ej_vld |-> !$isunknown(ej_flit));                                     // R10

  AST_INJ_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    inj_ok |-> inj_vld);                                                  // R8

  AST_INJ_IDLE_LINKS: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_vld && ((in_vld & EDGE_OK) == 4'b0000)) |-> inj_ok);             // R8
endmodule

bind deflect_router defr_checker #(
  .MESH_X(MESH_X), .MESH_Y(MESH_Y), .MY_X(MY_X), .MY_Y(MY_Y),
  .X_W(X_W), .Y_W(Y_W), .AGE_W(AGE_W), .PLD_W(PLD_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .inj_vld(inj_vld),
  .inj_ok(inj_ok), .out_vld(out_vld), .ej_vld(ej_vld), .ej_flit(ej_flit)
);

// File: tb/tb_deflect_router.sv
`timescale 1ns/1ps
module tb_deflect_router;
  localparam int MX = 4, MYY = 4, XW = 2, YW = 2, AW = 3, PW = 8;
  localparam int FW = XW + YW + AW + PW;
  localparam int NCYC = 400;
  localparam int AX = 1, AY = 2;   // interior node
  localparam int BX = 3, BY = 0;   // corner node: no South, no East

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst_n;
  logic [3:0]      in_vld;
  logic [4*FW-1:0] in_flit;
  logic            inj_vld;
  logic [FW-1:0]   inj_flit;

  logic a_iok, b_iok, a_ev, b_ev;
  logic [3:0] a_ov, b_ov;
  logic [4*FW-1:0] a_of, b_of;
  logic [FW-1:0] a_ef, b_ef;

  deflect_router #(.MESH_X(MX), .MESH_Y(MYY), .MY_X(AX), .MY_Y(AY),
                   .X_W(XW), .Y_W(YW), .AGE_W(AW), .PLD_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_flit(in_flit),
    .inj_vld(inj_vld), .inj_flit(inj_flit), .inj_ok(a_iok),
    .out_vld(a_ov), .out_flit(a_of), .ej_vld(a_ev), .ej_flit(a_ef));

  deflect_router #(.MESH_X(MX), .MESH_Y(MYY), .MY_X(BX), .MY_Y(BY),
                   .X_W(XW), .Y_W(YW), .AGE_W(AW), .PLD_W(PW)) dut_edge (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_flit(in_flit),
    .inj_vld(inj_vld), .inj_flit(inj_flit), .inj_ok(b_iok),
    .out_vld(b_ov), .out_flit(b_of), .ej_vld(b_ev), .ej_flit(b_ef));

  int checks = 0, errors = 0;

  logic [3:0] xa_ov, xb_ov;
  logic [4*FW-1:0] xa_of, xb_of;
  logic xa_ev, xb_ev, xa_iok, xb_iok;
  logic [FW-1:0] xa_ef, xb_ef;

  function automatic logic [FW-1:0] mk(int x, int y, int a, int p);
    return {p[PW-1:0], a[AW-1:0], y[YW-1:0], x[XW-1:0]};
  endfunction

  function automatic logic [FW-1:0] bump(logic [FW-1:0] f);
    logic [FW-1:0] r;
    int a;
    r = f;
    a = int'(f[XW+YW +: AW]);
    if (a < (1 << AW) - 1) a++;
    r[XW+YW +: AW] = a[AW-1:0];
    return r;
  endfunction

  function automatic int choose(int fr[4], int fx, int fy, int mx, int my);
    if (fx > mx && fr[2] != 0) return 2;
    if (fx < mx && fr[3] != 0) return 3;
    if (fy > my && fr[0] != 0) return 0;
    if (fy < my && fr[1] != 0) return 1;
    for (int i = 0; i < 4; i++) if (fr[i] != 0) return i;
    return 0;
  endfunction

  task automatic model(input int mx, input int my,
                       output logic [3:0] ov, output logic [4*FW-1:0] of,
                       output logic ev, output logic [FW-1:0] ef, output logic iok);
    int fr[4];
    int order[4];
    int n;
    bit used[4];
    fr[0] = (my < MYY - 1); fr[1] = (my > 0); fr[2] = (mx < MX - 1); fr[3] = (mx > 0);
    n = 0;
    for (int i = 0; i < 4; i++) used[i] = 0;
    for (int k = 0; k < 4; k++) begin
      int best;
      best = -1;
      for (int i = 0; i < 4; i++) begin
        if (in_vld[i] && fr[i] != 0 && !used[i]) begin
          if (best < 0) best = i;
          else if (in_flit[i*FW+XW+YW +: AW] > in_flit[best*FW+XW+YW +: AW]) best = i;
        end
      end
      if (best >= 0) begin used[best] = 1; order[n] = best; n++; end
    end
    ov = '0; of = '0; ev = 1'b0; ef = '0; iok = 1'b0;
    for (int k = 0; k < n; k++) begin
      int i, fx, fy;
      logic [FW-1:0] f;
      i = order[k];
      f = in_flit[i*FW +: FW];
      fx = int'(f[0 +: XW]);
      fy = int'(f[XW +: YW]);
      if (fx == mx && fy == my && !ev) begin
        ev = 1'b1; ef = bump(f);
      end else begin
        int p;
        p = choose(fr, fx, fy, mx, my);
        fr[p] = 0; ov[p] = 1'b1; of[p*FW +: FW] = bump(f);
      end
    end
    if (inj_vld && (fr[0] + fr[1] + fr[2] + fr[3]) > 0) begin
      int p;
      p = choose(fr, int'(inj_flit[0 +: XW]), int'(inj_flit[XW +: YW]), mx, my);
      iok = 1'b1; ov[p] = 1'b1; of[p*FW +: FW] = bump(inj_flit);
    end
  endtask

  task automatic cmp(string who, logic [3:0] ov, logic [4*FW-1:0] of, logic ev,
                     logic [FW-1:0] ef, logic [3:0] xov, logic [4*FW-1:0] xof,
                     logic xev, logic [FW-1:0] xef);
    checks++;
    if (ov !== xov) begin
      errors++;
      $display("FAIL %s R1 R4 R5 R6 R9 out_vld actual=%b expected=%b", who, ov, xov);
    end
    for (int p = 0; p < 4; p++) begin
      if (xov[p]) begin
        checks++;
        if (of[p*FW +: FW] !== xof[p*FW +: FW]) begin
          errors++;
          $display("FAIL %s R3 R4 R5 R7 R10 link %0d actual=%h expected=%h",
                   who, p, of[p*FW +: FW], xof[p*FW +: FW]);
        end
      end
    end
    checks++;
    if (ev !== xev || (xev && ef !== xef)) begin
      errors++;
      $display("FAIL %s R2 R3 R7 eject actual=%b/%h expected=%b/%h", who, ev, ef, xev, xef);
    end
  endtask

  task automatic stim(int c);
    inj_vld = 1'b0; inj_flit = '0; in_vld = '0; in_flit = '0;
    case (c)
      0: begin // R3 R5: four flits all heading east, tied and mixed ages
        in_vld = 4'b1111;
        in_flit = {mk(3,2,1,8'h44), mk(3,2,5,8'h33), mk(3,2,5,8'h22), mk(3,2,2,8'h11)};
        inj_vld = 1'b1; inj_flit = mk(1,0,0,8'h55);
      end
      1: begin // R2 R7: two flits for the interior node, one at max age
        in_vld = 4'b0011;
        in_flit[0 +: FW] = mk(1,2,7,8'hA1);
        in_flit[FW +: FW] = mk(1,2,3,8'hA2);
        inj_vld = 1'b1; inj_flit = mk(0,2,0,8'hA3);
      end
      2: begin in_vld = 4'b0001; in_flit[0 +: FW] = mk(2,3,7,8'hB1); end
      3: begin inj_vld = 1'b1; inj_flit = mk(3,3,4,8'hC1); end
      4: begin // R9: flits on links missing at the corner node
        in_vld = 4'b0110;
        in_flit[FW +: FW] = mk(3,0,2,8'hD1);
        in_flit[2*FW +: FW] = mk(0,3,2,8'hD2);
        inj_vld = 1'b1; inj_flit = mk(0,0,1,8'hD3);
      end
      5: begin // R8: every existing link busy, injection refused
        in_vld = 4'b1111;
        in_flit = {mk(0,3,1,8'hE4), mk(0,3,2,8'hE3), mk(0,3,3,8'hE2), mk(0,3,4,8'hE1)};
        inj_vld = 1'b1; inj_flit = mk(2,2,0,8'hE5);
      end
      default: begin
        in_vld = 4'($urandom);
        for (int i = 0; i < 4; i++)
          in_flit[i*FW +: FW] = mk(int'($urandom % 4), int'($urandom % 4),
                                   int'($urandom % 8), int'($urandom % 256));
        inj_vld = 1'($urandom);
        inj_flit = mk(int'($urandom % 4), int'($urandom % 4), int'($urandom % 8),
                      int'($urandom % 256));
      end
    endcase
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_vld = '0; in_flit = '0; inj_vld = 1'b0; inj_flit = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (a_ov !== 4'b0 || a_ev !== 1'b0 || b_ov !== 4'b0 || b_ev !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset valids actual=%b%b%b%b expected=0", a_ov, a_ev, b_ov, b_ev);
    end
    rst_n = 1'b1;
    xa_ov = '0; xa_of = '0; xa_ev = 1'b0; xa_ef = '0;
    xb_ov = '0; xb_of = '0; xb_ev = 1'b0; xb_ef = '0;
    for (int c = 0; c < NCYC; c++) begin
      @(negedge clk);
      cmp("interior", a_ov, a_of, a_ev, a_ef, xa_ov, xa_of, xa_ev, xa_ef);
      cmp("corner", b_ov, b_of, b_ev, b_ef, xb_ov, xb_of, xb_ev, xb_ef);
      stim(c);
      #1;
      model(AX, AY, xa_ov, xa_of, xa_ev, xa_ef, xa_iok);
      model(BX, BY, xb_ov, xb_of, xb_ev, xb_ef, xb_iok);
      checks++;
      if (a_iok !== xa_iok || b_iok !== xb_iok) begin
        errors++;
        $display("FAIL R8 inj_ok actual=%b/%b expected=%b/%b", a_iok, b_iok, xa_iok, xb_iok);
      end
    end
    @(negedge clk);
    cmp("interior", a_ov, a_of, a_ev, a_ef, xa_ov, xa_of, xa_ev, xa_ef);
    cmp("corner", b_ov, b_of, b_ev, b_ef, xb_ov, xb_of, xb_ev, xb_ef);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule